// File: doc/BRIEF.md
# Gated Pixel Clock Divider

This block turns a fast synthesis clock into a pixel clock for a scanning laser engine. The fast clock first passes through a free-running post-scaler (divide by 1, 2 or 4). A programmable divider then produces the pixel clock at one of nine moduli, with the high and low times equal even when the total period is an odd number of fast cycles. For odd periods the falling edge is placed on the falling edge of the fast clock.

The divider is gated by a beam-detect enable pin of programmable polarity. When the enable is asserted, the pixel clock phase restarts at the next post-scaler boundary. While the enable stays asserted the clock keeps running. When the enable is withdrawn, the period in progress finishes and the output then rests high until the next assertion.

A divider-off control bit stops the divider at once, whatever the enable pin does. A test selection hands the output level to a register bit so that a board tester can set the pin statically. Configuration fields are expected to change only while the divider rests.

Top module: `pixclk_gated_div`

## Requirements
- R1: After reset the divider is idle, the post-scaler phase is zero and `pclk_o` is high.
- R2: `div_code_i` selects the divider modulus K: 0000→3, 0001→4, 0010→4, 0011→5, 0100→6, 0101→8, 0110→8, 0111→10, 1000→12, 1001→16, 1010→16, and 1011 through 1111→20.
- R3: While running, the output period is K·S fast cycles, where S is the post-scaler ratio. Each period starts with a rising edge. The output is high for exactly half of the period, counted in half fast cycles; for odd K·S the fall occurs on a falling fast-clock edge.
- R4: The enable is active high when `en_pol_i` is 1 and active low when it is 0.
- R5: The enable level passes through SYNC_STAGES flops. An inactive-to-active change of the synchronized level requests a start. The new period begins at the first rising fast edge at which the post-scaler phase is at its last step, and this may be the same edge that sees the change.
- R6: A fresh start request that arrives while the divider runs abandons the current period and restarts the phase by the rule of R5.
- R7: If the synchronized enable is inactive when a period ends, the divider stops and `pclk_o` stays high. A period that is under way is never cut short by deassertion.
- R8: `scale_sel_i` 00, 01 and 10 give S = 1, 2 and 4. The post-scaler phase counter free-runs, and the enable input never resets it.
- R9: With `scale_sel_i` = 11, S is 1 and `pclk_o` equals the value `aux_level_i` had at the previous rising edge, whatever the divider state.
- R10: While `div_off_i` is 1, the divider stops at the next edge with `pclk_o` high, and start requests are discarded. Clearing the bit does not start the divider without a new enable assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (post-PLL) |
| rst | input | 1 | Synchronous active-high reset |
| en_pin_i | input | 1 | Beam-detect enable pin (asynchronous) |
| en_pol_i | input | 1 | Enable polarity: 1 active high, 0 active low |
| div_code_i | input | 4 | Divider modulus code |
| div_off_i | input | 1 | Divider off, overrides the enable |
| scale_sel_i | input | 2 | Post-scaler ratio / test selection |
| aux_level_i | input | 1 | Static output level in test selection |
| pclk_o | output | 1 | Pixel clock |

## Verification
The bench instantiates the block with SYNC_STAGES raised to 3 and leaves the default maximum modulus and scale. This exercises the synchronizer latency as a parameter and reaches the longest period of 80 fast cycles. A behavioural model predicts the output for both halves of every fast cycle. The bench runs a sweep over all sixteen codes, starts placed at every post-scaler phase, both enable polarities, mid-period restarts, disable overrides and the test selection. Sampling on both halves makes the half-cycle falling edge of odd periods directly visible.

// File: rtl/pixclk_pkg.sv
`timescale 1ns/1ps
package pixclk_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 2;
  localparam int MOD_W  = 5;
  localparam int SCL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SCL_DIV1 = 2'b00,
    SCL_DIV2 = 2'b01,
    SCL_DIV4 = 2'b10,
    SCL_AUX  = 2'b11
  } scale_sel_e;

  // Modulus decode for the divider code (R2)
  function automatic logic [MOD_W-1:0] modulus_of(input logic [CODE_W-1:0] code);
    logic [MOD_W-1:0] k;
    case (code)
      4'd0:    k = MOD_W'(3);
      4'd1:    k = MOD_W'(4);
      4'd2:    k = MOD_W'(4);
      4'd3:    k = MOD_W'(5);
      4'd4:    k = MOD_W'(6);
      4'd5:    k = MOD_W'(8);
      4'd6:    k = MOD_W'(8);
      4'd7:    k = MOD_W'(10);
      4'd8:    k = MOD_W'(12);
      4'd9:    k = MOD_W'(16);
      4'd10:   k = MOD_W'(16);
      default: k = MOD_W'(20);
    endcase
    return k;
  endfunction
endpackage

// File: rtl/pixclk_en_sync.sv
`timescale 1ns/1ps
module pixclk_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              act;

  // R4: polarity applied before synchronization
  assign act = pol_i ? pin_i : ~pin_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= (sh_q << 1) | STAGES'(act);
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pixclk_post_scaler.sv
`timescale 1ns/1ps
module pixclk_post_scaler
  import pixclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SCL_W-1:0] scale_o,
  output logic             tick_o
);
  localparam int PH_W = SCL_W - 1;

  logic [PH_W-1:0] ph_q;

  always_comb begin
    case (scale_sel_e'(sel_i))
      SCL_DIV2: scale_o = SCL_W'(2);
      SCL_DIV4: scale_o = SCL_W'(4);
      default:  scale_o = SCL_W'(1);
    endcase
  end

  // last step of the post-scaler phase; >= tolerates a ratio change
  assign tick_o = ({1'b0, ph_q} >= (scale_o - 1'b1));

  // R8: free-running, never touched by the enable
  always_ff @(posedge clk) begin
    if (rst)         ph_q <= '0;
    else if (tick_o) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end

  // R8
  div2_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SCL_DIV2 && $stable(sel_i) && tick_o) |-> !$past(tick_o));
endmodule

// File: rtl/pixclk_phase_div.sv
`timescale 1ns/1ps
module pixclk_phase_div #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             level_i,
  input  logic             off_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             clk_o
);
  logic             run_q;
  logic             pend_q;
  logic             hi_p_q;
  logic             hi_n_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             wrap;
  logic             go;
  logic             hi_next;

  assign cnt_inc = cnt_q + 1'b1;
  assign wrap    = (cnt_q >= (period_i - 1'b1));
  assign go      = !off_i && (pend_q || rise_i) && tick_i;
  // high on the rising phase while the whole next cycle lies in the first half
  assign hi_next = ({cnt_inc, 1'b1} < {1'b0, period_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_p_q <= 1'b1;
    end else if (off_i) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_p_q <= 1'b1;
    end else if (go) begin
      run_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_p_q <= 1'b1;
    end else begin
      if (rise_i) pend_q <= 1'b1;
      if (!run_q) begin
        hi_p_q <= 1'b1;
      end else if (wrap) begin
        cnt_q  <= '0;
        hi_p_q <= 1'b1;
        run_q  <= level_i;
      end else begin
        cnt_q  <= cnt_inc;
        hi_p_q <= hi_next;
      end
    end
  end

  // half-cycle extension for odd periods (R3)
  always_ff @(negedge clk) begin
    if (rst) hi_n_q <= 1'b0;
    else     hi_n_q <= hi_p_q & period_i[0];
  end

  assign clk_o = hi_p_q | hi_n_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $stable(period_i)) |-> (cnt_q < period_i));

  // R10
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    off_i |=> (!run_q && clk_o));

  // R7
  park_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && wrap && !level_i && !go && !off_i) |=> (!run_q && clk_o));

  // R5
  start_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> (run_q && cnt_q == '0 && clk_o));
endmodule

// File: rtl/pixclk_gated_div.sv
`timescale 1ns/1ps
module pixclk_gated_div
  import pixclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_MOD     = 20,
  parameter int MAX_SCALE   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_pin_i,
  input  logic              en_pol_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              div_off_i,
  input  logic [SEL_W-1:0]  scale_sel_i,
  input  logic              aux_level_i,
  output logic              pclk_o
);
  localparam int CNT_W = $clog2(MAX_MOD * MAX_SCALE + 1);

  logic             level;
  logic             rise;
  logic             tick;
  logic [SCL_W-1:0] scale;
  logic [CNT_W-1:0] period;
  logic             div_clk;
  logic             tst_q;
  logic             aux_q;

  pixclk_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (en_pin_i),
    .pol_i   (en_pol_i),
    .level_o (level),
    .rise_o  (rise)
  );

  pixclk_post_scaler u_scale (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (scale_sel_i),
    .scale_o (scale),
    .tick_o  (tick)
  );

  assign period = CNT_W'(modulus_of(div_code_i)) * CNT_W'(scale);

  pixclk_phase_div #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .rise_i   (rise),
    .level_i  (level),
    .off_i    (div_off_i),
    .period_i (period),
    .clk_o    (div_clk)
  );

  // R9: test selection and level registered
  always_ff @(posedge clk) begin
    if (rst) begin
      tst_q <= 1'b0;
      aux_q <= 1'b0;
    end else begin
      tst_q <= (scale_sel_i == SCL_AUX);
      aux_q <= aux_level_i;
    end
  end

  assign pclk_o = tst_q ? aux_q : div_clk;

  // R9
  aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scale_sel_i == SCL_AUX && $stable(scale_sel_i) && $stable(aux_level_i))
      |=> $stable(pclk_o));
endmodule

// File: tb/tb_pixclk_gated_div.sv
`timescale 1ns/1ps
module tb_pixclk_gated_div;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_pin = 1'b0;
  logic       en_pol = 1'b1;
  logic [3:0] code = 4'd0;
  logic       off = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       aux = 1'b0;
  logic       pclk;

  int    errors = 0;
  int    checks = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  pixclk_gated_div #(.SYNC_STAGES(SYNC)) dut (
    .clk         (clk),
    .rst         (rst),
    .en_pin_i    (en_pin),
    .en_pol_i    (en_pol),
    .div_code_i  (code),
    .div_off_i   (off),
    .scale_sel_i (sel),
    .aux_level_i (aux),
    .pclk_o      (pclk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int mod_ref(input logic [3:0] c);
    case (c)
      0: return 3;   1: return 4;   2: return 4;   3: return 5;
      4: return 6;   5: return 8;   6: return 8;   7: return 10;
      8: return 12;  9: return 16;  10: return 16;
      default: return 20;
    endcase
  endfunction

  // behavioural reference model, one update per rising edge
  int            m_ph = 0, m_pos = 0;
  bit            m_run = 0, m_pend = 0, m_ed = 0, m_tq = 0, m_aq = 0;
  logic [SYNC-1:0] m_sh = '0;
  bit            exp_a = 1, exp_b = 1;

  always @(posedge clk) begin
    int s, p;
    bit es, rise, tk, act;
    s = (sel == 2'b01) ? 2 : (sel == 2'b10) ? 4 : 1;
    p = mod_ref(code) * s;
    if (rst) begin
      m_ph = 0; m_pos = 0; m_run = 0; m_pend = 0; m_ed = 0;
      m_sh = '0; m_tq = 0; m_aq = 0;
    end else begin
      es   = m_sh[SYNC-1];
      rise = es && !m_ed;
      tk   = (m_ph >= s - 1);
      act  = en_pol ? en_pin : !en_pin;
      if (off) begin
        m_run = 0; m_pend = 0; m_pos = 0;
      end else if ((m_pend || rise) && tk) begin
        m_run = 1; m_pend = 0; m_pos = 0;
      end else begin
        if (rise) m_pend = 1;
        if (m_run) begin
          if (m_pos >= p - 1) begin
            m_pos = 0;
            if (!es) m_run = 0;
          end else begin
            m_pos = m_pos + 1;
          end
        end
      end
      m_ed = es;
      m_sh = {m_sh[SYNC-2:0], act};
      m_ph = tk ? 0 : m_ph + 1;
      m_tq = (sel == 2'b11);
      m_aq = aux;
    end
    if (m_tq) begin
      exp_a = m_aq; exp_b = m_aq;
    end else if (!m_run) begin
      exp_a = 1; exp_b = 1;
    end else begin
      exp_a = (2 * m_pos < p);
      exp_b = (2 * m_pos + 1 < p);
    end
  end

  task automatic check(input logic got, input bit exp, input string half);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s half at %0t: got=%0b exp=%0b", cur_req, half, $time, got, exp);
    end
  endtask

  always begin
    @(posedge clk); #3;
    if (chk_on) check(pclk, exp_a, "first");
  end
  always begin
    @(negedge clk); #3;
    if (chk_on) check(pclk, exp_b, "second");
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    chk_on = 1'b1;
    cur_req = "R1";
    cyc(6);

    // R2 and R3: sweep every code at S=1, three periods each, then park (R7)
    for (int c = 0; c < 16; c++) begin
      code = 4'(c);
      cur_req = (mod_ref(4'(c)) % 2 == 1) ? "R3" : "R2";
      cyc(2);
      en_pin = 1'b1;
      cyc(3 * mod_ref(4'(c)) + SYNC + 4);
      cur_req = "R7";
      en_pin = 1'b0;
      cyc(mod_ref(4'(c)) + SYNC + 6);
    end

    // R8: ratios 2 and 4 with short and long moduli
    cur_req = "R8";
    for (int sv = 1; sv <= 2; sv++) begin
      sel = 2'(sv);
      foreach (code[i]) begin end
      for (int j = 0; j < 3; j++) begin
        code = (j == 0) ? 4'd0 : (j == 1) ? 4'd3 : 4'd11;
        cyc(3);
        en_pin = 1'b1;
        cyc(2 * mod_ref(code) * 4 + 10);
        en_pin = 1'b0;
        cyc(mod_ref(code) * 4 + 12);
      end
    end

    // R5: start placed at every post-scaler phase, S=4, K=3
    cur_req = "R5";
    sel = 2'b10; code = 4'd0;
    for (int d = 0; d < 4; d++) begin
      cyc(d + 1);
      en_pin = 1'b1;
      cyc(30);
      en_pin = 1'b0;
      cyc(30);
    end

    // R4: active-low enable, K=5, S=1
    cur_req = "R4";
    sel = 2'b00; code = 4'd3;
    en_pin = 1'b1; en_pol = 1'b0;
    cyc(10);
    en_pin = 1'b0;
    cyc(30);
    en_pin = 1'b1;
    cyc(25);
    en_pol = 1'b1; en_pin = 1'b0;
    cyc(10);

    // R6: restart in the middle of a period, K=20
    cur_req = "R6";
    code = 4'd11;
    en_pin = 1'b1;
    cyc(27);
    en_pin = 1'b0;
    cyc(2);
    en_pin = 1'b1;
    cyc(50);
    en_pin = 1'b0;
    cyc(40);

    // R10: divider off overrides the enable
    cur_req = "R10";
    code = 4'd5;
    en_pin = 1'b1;
    cyc(12);
    off = 1'b1;
    cyc(6);
    en_pin = 1'b0;
    cyc(6);
    en_pin = 1'b1;
    cyc(6);
    off = 1'b0;
    cyc(30);
    en_pin = 1'b0;
    cyc(6);
    en_pin = 1'b1;
    cyc(30);
    en_pin = 1'b0;
    cyc(20);

    // R9: test selection, static level from the aux bit
    cur_req = "R9";
    sel = 2'b11;
    cyc(3);
    aux = 1'b1; cyc(4);
    aux = 1'b0; cyc(3);
    en_pin = 1'b1; cyc(5);
    aux = 1'b1; cyc(1);
    aux = 1'b0; cyc(7);
    aux = 1'b1; cyc(6);
    en_pin = 1'b0; cyc(30);
    sel = 2'b00; aux = 1'b0;
    cyc(10);

    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule